// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block resolves one interrupt destination against a table of local interrupt-controller agents and produces a delivery mask with one bit per agent. Each table slot describes one agent: whether the slot is populated, whether the agent runs in the compatible 8-bit addressing mode or the extended 32-bit mode, its full 32-bit identifier, its short 8-bit identifier, its 8-bit logical identifier, and whether its compatible logical model is flat or clustered. The extended logical identifier is not stored. It is derived from the full identifier.

A request carries a 32-bit destination and a single bit that selects physical or logical addressing. Both modes resolve the destination against a mixed population of agents. Compatible-mode agents and extended-mode agents each apply their own direct-match, logical-match and broadcast rules, so one destination can select agents of both kinds at once. The result is registered. The mask appears, together with a one-cycle strobe, on the clock after the request strobe. At all other times the mask is zero.

Top module: `irq_dest_gen`

## Requirements
- R1: After reset and in every cycle without a result strobe, `mask_valid` is 0 and `mask` is all zeros.
- R2: A request sampled with `req_valid` high at a rising edge produces `mask_valid` high for exactly one cycle, starting at that edge, with `mask` holding that request's result.
- R3: In physical mode (`req_logical`=0), an extended-mode agent is selected when its full 32-bit ID equals the whole destination.
- R4: In physical mode, a compatible-mode agent is selected when its 8-bit ID equals destination bits 7:0. The upper 24 bits are ignored.
- R5: In physical mode, destination 0xFFFFFFFF selects every populated agent.
- R6: In physical mode, destination 0x000000FF selects every compatible-mode agent. An extended-mode agent is selected by it only through R3.
- R7: In logical mode (`req_logical`=1), destination 0xFFFFFFFF selects every extended-mode agent. Compatible-mode agents are still judged by R9 and R10 using bits 7:0.
- R8: In logical mode, an extended-mode agent is selected when destination bits 31:16 equal its logical bits 31:16 and destination bits 15:0 AND its logical bits 15:0 is nonzero. The logical ID is formed as bits 31:16 = full ID bits 19:4, and bits 15:0 = a single one at position full ID bits 3:0.
- R9: In logical mode, a compatible agent in the flat model (`agent_cluster` bit 0) is selected when destination bits 7:0 AND its logical ID is nonzero.
- R10: In logical mode, a compatible agent in the cluster model (`agent_cluster` bit 1) is selected when the destination cluster (bits 7:4) equals its own cluster (logical ID bits 7:4) or equals 0xF, and destination bits 3:0 AND logical ID bits 3:0 is nonzero.
- R11: A slot whose `agent_valid` bit is 0 is never selected, whatever the destination or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 32 | Destination value |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| agent_valid | input | NUM_AGENTS | Slot populated |
| agent_ext | input | NUM_AGENTS | 1 = extended mode, 0 = compatible mode |
| agent_cluster | input | NUM_AGENTS | Compatible logical model: 1 = cluster, 0 = flat |
| agent_full_id | input | 32*NUM_AGENTS | Full identifier, slot i in bits 32i+31:32i |
| agent_short_id | input | 8*NUM_AGENTS | 8-bit identifier, slot i in bits 8i+7:8i |
| agent_logical_id | input | 8*NUM_AGENTS | 8-bit logical identifier, slot i in bits 8i+7:8i |
| mask_valid | output | 1 | One-cycle result strobe |
| mask | output | NUM_AGENTS | Delivery mask, bit i selects slot i |

## Verification
The bench sweeps every destination low byte under several upper-half patterns, in both modes, over four mixed tables. It adds the exact values 0xFF, 0xFFFFFFFF and full extended IDs above 255. Three errors are each caught this way. A design that treats 0xFF as a match on the low byte alone would wrongly select compatible agents for destinations such as 0xFFFF. A design that lets logical all-ones reach every agent would select compatible agents whose logical ID has no overlap. A design that drops the cluster broadcast would miss cluster 0xF destinations. The derived extended logical ID is checked with identifiers whose low nibble is 8 or more, so a member bit in destination bits 15:8 has to match. An invalid slot holding a matching ID must stay clear in the mask, and the mask must return to zero one cycle after each strobe.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

    localparam int DEST_W    = 32;
    localparam int SHORT_W   = 8;
    localparam int HALF_W    = DEST_W / 2;
    localparam int NIBBLE_W  = 4;

    localparam logic [DEST_W-1:0] DEST_ALL_ONES = '1;
    localparam logic [DEST_W-1:0] DEST_SHORT_BC = DEST_W'(8'hFF);
    localparam logic [NIBBLE_W-1:0] CLUSTER_ALL = '1;

    // Extended logical ID: cluster = full_id >> 4 in the upper half,
    // one-hot member bit from full_id[3:0] in the lower half.
    function automatic logic [DEST_W-1:0] ext_logical_id(input logic [DEST_W-1:0] full_id);
        logic [HALF_W-1:0] member;
        member = '0;
        member[full_id[NIBBLE_W-1:0]] = 1'b1;
        return {full_id[HALF_W+NIBBLE_W-1:NIBBLE_W], member};
    endfunction

endpackage

// File: rtl/irq_dest_phys.sv
module irq_dest_phys
    import irq_dest_pkg::*;
(
    input  logic [DEST_W-1:0]  dest,
    input  logic               ext_mode,
    input  logic [DEST_W-1:0]  full_id,
    input  logic [SHORT_W-1:0] short_id,
    output logic               hit
);
    logic all_bc;
    logic short_bc;
    logic ext_hit;
    logic cmp_hit;

    always_comb begin
        all_bc   = (dest == DEST_ALL_ONES);
        short_bc = (dest == DEST_SHORT_BC);
        ext_hit  = (full_id == dest);
        cmp_hit  = (short_id == dest[SHORT_W-1:0]) || short_bc;
        hit      = all_bc || (ext_mode ? ext_hit : cmp_hit);
    end
endmodule

// File: rtl/irq_dest_logical.sv
module irq_dest_logical
    import irq_dest_pkg::*;
(
    input  logic [DEST_W-1:0]  dest,
    input  logic               ext_mode,
    input  logic               cluster_model,
    input  logic [DEST_W-1:0]  full_id,
    input  logic [SHORT_W-1:0] logical_id,
    output logic               hit
);
    logic [DEST_W-1:0]   xldr;
    logic [SHORT_W-1:0]  d8;
    logic                ext_hit;
    logic                flat_hit;
    logic                clus_sel;
    logic                clus_hit;

    always_comb begin
        xldr     = ext_logical_id(full_id);
        ext_hit  = (dest == DEST_ALL_ONES) ||
                   ((dest[DEST_W-1:HALF_W] == xldr[DEST_W-1:HALF_W]) &&
                    (|(dest[HALF_W-1:0] & xldr[HALF_W-1:0])));
        d8       = dest[SHORT_W-1:0];
        flat_hit = |(d8 & logical_id);
        clus_sel = (d8[SHORT_W-1:NIBBLE_W] == CLUSTER_ALL) ||
                   (d8[SHORT_W-1:NIBBLE_W] == logical_id[SHORT_W-1:NIBBLE_W]);
        clus_hit = clus_sel && (|(d8[NIBBLE_W-1:0] & logical_id[NIBBLE_W-1:0]));
        if (ext_mode)
            hit = ext_hit;
        else if (cluster_model)
            hit = clus_hit;
        else
            hit = flat_hit;
    end
endmodule

// File: rtl/irq_dest_gen.sv
module irq_dest_gen
    import irq_dest_pkg::*;
#(
    parameter int NUM_AGENTS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [DEST_W-1:0]             req_dest,
    input  logic                          req_logical,
    input  logic [NUM_AGENTS-1:0]         agent_valid,
    input  logic [NUM_AGENTS-1:0]         agent_ext,
    input  logic [NUM_AGENTS-1:0]         agent_cluster,
    input  logic [NUM_AGENTS*DEST_W-1:0]  agent_full_id,
    input  logic [NUM_AGENTS*SHORT_W-1:0] agent_short_id,
    input  logic [NUM_AGENTS*SHORT_W-1:0] agent_logical_id,
    output logic                          mask_valid,
    output logic [NUM_AGENTS-1:0]         mask
);
    typedef struct packed {
        logic                  vld;
        logic [NUM_AGENTS-1:0] sel;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_AGENTS-1:0] phys_hit;
    logic [NUM_AGENTS-1:0] log_hit;
    logic [NUM_AGENTS-1:0] hit_all;

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
        irq_dest_phys u_phys (
            .dest     (req_dest),
            .ext_mode (agent_ext[i]),
            .full_id  (agent_full_id[i*DEST_W +: DEST_W]),
            .short_id (agent_short_id[i*SHORT_W +: SHORT_W]),
            .hit      (phys_hit[i])
        );

        irq_dest_logical u_log (
            .dest          (req_dest),
            .ext_mode      (agent_ext[i]),
            .cluster_model (agent_cluster[i]),
            .full_id       (agent_full_id[i*DEST_W +: DEST_W]),
            .logical_id    (agent_logical_id[i*SHORT_W +: SHORT_W]),
            .hit           (log_hit[i])
        );

        assign hit_all[i] = agent_valid[i] & (req_logical ? log_hit[i] : phys_hit[i]);

        AST_INVALID_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !agent_valid[i]) |=> !mask[i]);  // R11

        AST_PHYS_EXT_EQ: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_logical && agent_valid[i] && agent_ext[i] &&
             req_dest == agent_full_id[i*DEST_W +: DEST_W]) |=> mask[i]);  // R3

        AST_SHORT_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_logical && agent_valid[i] && !agent_ext[i] &&
             req_dest == DEST_SHORT_BC) |=> mask[i]);  // R6

        AST_LOG_BCAST_EXT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_logical && agent_valid[i] && agent_ext[i] &&
             req_dest == DEST_ALL_ONES) |=> mask[i]);  // R7
    end

    always_comb begin
        st_d     = '0;
        st_d.vld = req_valid;
        if (req_valid)
            st_d.sel = hit_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign mask_valid = st_q.vld;
    assign mask       = st_q.sel;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_valid |-> (mask == '0));  // R1

    AST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> mask_valid);  // R2

    AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_logical && req_dest == DEST_ALL_ONES) |=>
        (mask == $past(agent_valid)));  // R5

endmodule

// File: tb/irq_dest_gen_bench.sv
module irq_dest_gen_bench;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_dest = '0;
    logic req_logical = 1'b0;
    logic [N-1:0] a_valid = '0, a_ext = '0, a_clus = '0;
    logic [N*32-1:0] a_full = '0;
    logic [N*8-1:0] a_short = '0, a_ldr = '0;
    logic mask_valid;
    logic [N-1:0] mask;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    irq_dest_gen #(.NUM_AGENTS(N)) u_irq_dest_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_logical(req_logical), .agent_valid(a_valid), .agent_ext(a_ext),
        .agent_cluster(a_clus), .agent_full_id(a_full), .agent_short_id(a_short),
        .agent_logical_id(a_ldr), .mask_valid(mask_valid), .mask(mask)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic set_agent(input int i, input bit v, input bit e, input bit c,
                             input logic [31:0] f, input logic [7:0] s, input logic [7:0] l);
        a_valid[i] = v; a_ext[i] = e; a_clus[i] = c;
        a_full[i*32 +: 32] = f; a_short[i*8 +: 8] = s; a_ldr[i*8 +: 8] = l;
    endtask

    task automatic load_cfg(input int k);
        case (k)
            0: begin
                set_agent(0, 1, 1, 0, 32'h13,  8'h00, 8'h00);
                set_agent(1, 1, 0, 0, 32'h0,   8'h05, 8'h21);
                set_agent(2, 1, 0, 1, 32'h0,   8'h31, 8'h12);
                set_agent(3, 1, 1, 0, 32'h1FF, 8'h00, 8'h00);
            end
            1: begin
                set_agent(0, 1, 1, 0, 32'h1A,  8'h00, 8'h00);
                set_agent(1, 0, 0, 0, 32'h13,  8'h05, 8'hFF);
                set_agent(2, 1, 0, 1, 32'h0,   8'h40, 8'h28);
                set_agent(3, 1, 0, 1, 32'h0,   8'hFF, 8'hF4);
            end
            2: begin
                set_agent(0, 1, 0, 0, 32'h0,   8'h00, 8'h80);
                set_agent(1, 1, 0, 1, 32'h0,   8'h7E, 8'h01);
                set_agent(2, 1, 0, 0, 32'h0,   8'hA5, 8'h00);
                set_agent(3, 0, 1, 0, 32'hFF,  8'hFF, 8'hFF);
            end
            default: begin
                set_agent(0, 1, 1, 0, 32'h10,  8'h10, 8'h01);
                set_agent(1, 1, 1, 0, 32'h11,  8'h11, 8'h02);
                set_agent(2, 1, 1, 0, 32'h2F,  8'hFF, 8'h04);
                set_agent(3, 1, 1, 0, 32'hFF,  8'h00, 8'h08);
            end
        endcase
    endtask

    function automatic bit exp_hit(input int i, input logic [31:0] d, input bit lg,
                                   output string tag);
        logic [31:0] f, x;
        logic [7:0] l, d8;
        f = a_full[i*32 +: 32];
        l = a_ldr[i*8 +: 8];
        d8 = d[7:0];
        if (!a_valid[i]) begin tag = "R11"; return 1'b0; end
        if (!lg) begin
            if (d == 32'hFFFF_FFFF) begin tag = "R5"; return 1'b1; end
            if (a_ext[i]) begin tag = "R3"; return f == d; end
            if (d == 32'hFF) begin tag = "R6"; return 1'b1; end
            tag = "R4";
            return a_short[i*8 +: 8] == d8;
        end
        if (a_ext[i]) begin
            if (d == 32'hFFFF_FFFF) begin tag = "R7"; return 1'b1; end
            tag = "R8";
            x = ((f >> 4) << 16) | (32'h1 << (f % 16));
            return ((d >> 16) == (x >> 16)) && ((d % 65536) & (x % 65536)) != 0;
        end
        if (a_clus[i]) begin
            tag = "R10";
            return ((d8 / 16 == 15) || (d8 / 16 == l / 16)) && ((d8 % 16) & (l % 16)) != 0;
        end
        tag = "R9";
        return (d8 & l) != 0;
    endfunction

    task automatic run_one(input logic [31:0] d, input bit lg);
        string tag;
        bit e;
        @(negedge clk);
        req_valid = 1'b1; req_dest = d; req_logical = lg;
        @(negedge clk);
        req_valid = 1'b0;
        total++;
        if (mask_valid !== 1'b1) begin
            bad++;
            $display("FAIL R2 strobe: actual=%b expected=1", mask_valid);
        end
        for (int i = 0; i < N; i++) begin
            e = exp_hit(i, d, lg, tag);
            total++;
            if (mask[i] !== e) begin
                bad++;
                $display("FAIL %s agent %0d dest=%h logical=%0b: actual=%b expected=%b",
                         tag, i, d, lg, mask[i], e);
            end
        end
        @(negedge clk);
        total++;
        if (mask_valid !== 1'b0 || mask !== '0) begin
            bad++;
            $display("FAIL R1 idle: actual=%b/%h expected=0/0", mask_valid, mask);
        end
    endtask

    initial begin
        logic [31:0] hi [4];
        logic [31:0] extra [5];
        hi[0] = 32'h0; hi[1] = 32'h0001_0000; hi[2] = 32'h0002_0000; hi[3] = 32'hFFFF_0000;
        extra[0] = 32'hFF; extra[1] = 32'hFFFF_FFFF; extra[2] = 32'h1FF;
        extra[3] = 32'h13; extra[4] = 32'h0001_FFFF;
        load_cfg(0);
        repeat (3) @(negedge clk);
        total++;
        if (mask_valid !== 1'b0 || mask !== '0) begin
            bad++;
            $display("FAIL R1 reset: actual=%b/%h expected=0/0", mask_valid, mask);
        end
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            load_cfg(k);
            for (int lg = 0; lg < 2; lg++) begin
                for (int h = 0; h < 4; h++)
                    for (int b = 0; b < 256; b++)
                        run_one(hi[h] | (32'(b) << 8) | 32'(b), lg[0]);
                for (int x = 0; x < 5; x++)
                    run_one(extra[x], lg[0]);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule